// File: doc/BRIEF.md
# Dual-Bus Register Set with Tri-State Ports

This block holds four 8-bit registers that sit between two shared bidirectional data buses, called A and B. Each bus has its own 2-bit register address and its own 2-bit operation code. In any clock cycle a bus can be idle, can load the addressed register from the bus, or can have the addressed register placed onto it through tri-state drivers. The two buses work independently. One bus can write a register while the other bus reads a different register, or the same one, in the same cycle.

Each register has a 2:1 input multiplexer that picks A-bus or B-bus data. A load decode drives the multiplexer select. The register captures data on the rising clock edge. A bus that is not being driven by the block is left at high impedance so that an external agent can own it. Reads are combinational from the stored contents, so a driven bus shows the addressed register within the cycle the drive is requested.

Top module: `dual_bus_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears all four registers to 8'h00 on a rising edge.
- R2: Operation codes on `a_op` and `b_op` are 2'b00 idle, 2'b01 load and 2'b10 drive. Code 2'b11 behaves as idle. The two buses must never load the same register in one cycle.
- R3: With `a_op` = load, the register numbered `a_addr` takes the value on `a_bus` at the next rising edge.
- R4: With `b_op` = load, the register numbered `b_addr` takes the value on `b_bus` at the next rising edge.
- R5: With a bus op = drive, that bus carries the current contents of the register given by its address before the next rising edge.
- R6: A register that neither bus loads keeps its value across the edge.
- R7: A bus whose op is idle, load or 2'b11 is not driven by the block, so a value an external agent places on it reads back unchanged.
- R8: Loading register i from one bus while the other bus drives register 3-i in the same cycle completes both operations correctly.
- R9: When one bus loads a register that the other bus drives in the same cycle, the driven bus shows the value from before the edge, and the new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers capture on the rising edge |
| rst | input | 1 | Synchronous active-high clear |
| a_addr | input | 2 | Register number for bus A |
| a_op | input | 2 | Bus A operation: idle, load, drive |
| a_bus | inout | 8 | Bidirectional data bus A |
| b_addr | input | 2 | Register number for bus B |
| b_op | input | 2 | Bus B operation: idle, load, drive |
| b_bus | inout | 8 | Bidirectional data bus B |

## Verification
The bench mixes seeded random traffic with directed cases: a load on one bus crossed with a drive on the other bus to the mirrored register, and a load and a drive on the same register in one cycle. A design with a wrong multiplexer select would store B data on an A load, and the bench catches that on a later read. A design that captured on the wrong edge or passed data straight through would show the new value on the same-register drive too early. The bench also places its own pattern on every bus that is idle, loading or carrying code 2'b11. A design that drives a bus it should leave alone would corrupt that pattern.

// File: rtl/drb_pkg.sv
package drb_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_DRIVE = 2'b10,
    OP_RSVD  = 2'b11
  } bus_op_e;
endpackage

// File: rtl/drb_decoder.sv
module drb_decoder #(
  parameter int ADDR_W = 2,
  parameter int NREG   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit
);
  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign hit[g] = en && (addr == ADDR_W'(g));
  end

  // R2: a decode selects at most one register
  p_dec_onehot_r2: assert property (@(posedge clk) disable iff (rst) $onehot0(hit));
endmodule

// File: rtl/drb_cell.sv
module drb_cell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         take_a,
  input  logic [W-1:0] a_d,
  input  logic [W-1:0] b_d,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;
  assign nxt = take_a ? a_d : b_d;

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= nxt;
  end

  // R6: an unloaded register holds
  p_hold_r6: assert property (@(posedge clk) disable iff (rst) !ld |=> $stable(q));
endmodule

// File: rtl/drb_read_mux.sv
module drb_read_mux #(
  parameter int W      = 8,
  parameter int NREG   = 4,
  parameter int ADDR_W = 2
) (
  input  logic [NREG-1:0][W-1:0] regs,
  input  logic [ADDR_W-1:0]      addr,
  output logic [W-1:0]           val
);
  assign val = regs[addr];
endmodule

// File: rtl/dual_bus_regfile.sv
module dual_bus_regfile #(
  parameter int W    = 8,
  parameter int NREG = 4,
  localparam int ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [1:0]        a_op,
  inout  wire  [W-1:0]      a_bus,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [1:0]        b_op,
  inout  wire  [W-1:0]      b_bus
);
  import drb_pkg::*;

  logic a_is_ld, b_is_ld, a_is_drv, b_is_drv;
  assign a_is_ld  = (a_op == OP_LOAD);
  assign b_is_ld  = (b_op == OP_LOAD);
  assign a_is_drv = (a_op == OP_DRIVE);
  assign b_is_drv = (b_op == OP_DRIVE);

  logic [NREG-1:0] a_ld_hit, b_ld_hit;

  drb_decoder #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec_a (
    .clk(clk), .rst(rst), .en(a_is_ld), .addr(a_addr), .hit(a_ld_hit));
  drb_decoder #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec_b (
    .clk(clk), .rst(rst), .en(b_is_ld), .addr(b_addr), .hit(b_ld_hit));

  logic [NREG-1:0][W-1:0] regs;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    drb_cell #(.W(W)) u_cell (
      .clk(clk), .rst(rst),
      .ld(a_ld_hit[g] | b_ld_hit[g]),
      .take_a(a_ld_hit[g]),
      .a_d(a_bus), .b_d(b_bus),
      .q(regs[g]));

    // R3: an A load lands in the addressed register
    p_a_load_r3: assert property (@(posedge clk) disable iff (rst)
      (a_is_ld && a_addr == ADDR_W'(g)) |=> regs[g] == $past(a_bus));
    // R4: a B load lands in the addressed register
    p_b_load_r4: assert property (@(posedge clk) disable iff (rst)
      (b_is_ld && b_addr == ADDR_W'(g)) |=> regs[g] == $past(b_bus));
  end

  logic [W-1:0] a_rd, b_rd;
  drb_read_mux #(.W(W), .NREG(NREG), .ADDR_W(ADDR_W)) u_rd_a (
    .regs(regs), .addr(a_addr), .val(a_rd));
  drb_read_mux #(.W(W), .NREG(NREG), .ADDR_W(ADDR_W)) u_rd_b (
    .regs(regs), .addr(b_addr), .val(b_rd));

  assign a_bus = a_is_drv ? a_rd : 'z;
  assign b_bus = b_is_drv ? b_rd : 'z;

  // R2: both buses never load the same register together
  p_no_dual_load_r2: assert property (@(posedge clk) disable iff (rst)
    !(a_is_ld && b_is_ld && a_addr == b_addr));
  // R5: a driven bus carries the addressed register
  p_a_drive_r5: assert property (@(posedge clk) disable iff (rst)
    a_is_drv |-> a_bus == regs[a_addr]);
  p_b_drive_r5: assert property (@(posedge clk) disable iff (rst)
    b_is_drv |-> b_bus == regs[b_addr]);
endmodule

// File: tb/dual_bus_regfile_bench.sv
module dual_bus_regfile_bench;
  logic clk = 0;
  logic rst;
  logic [1:0] a_addr, b_addr, a_op, b_op;
  logic [7:0] tb_a, tb_b;
  logic tb_a_en, tb_b_en;
  wire  [7:0] a_bus, b_bus;
  int n_run = 0, n_fail = 0;
  logic [7:0] model [4];
  bit done = 0;

  assign a_bus = tb_a_en ? tb_a : 'z;
  assign b_bus = tb_b_en ? tb_b : 'z;

  always #5 clk = ~clk;

  dual_bus_regfile u_dual_bus_regfile (
    .clk(clk), .rst(rst), .a_addr(a_addr), .a_op(a_op), .a_bus(a_bus),
    .b_addr(b_addr), .b_op(b_op), .b_bus(b_bus));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Ops: 0 idle, 1 load, 2 drive, 3 reserved (idle).
  task automatic step(input logic [1:0] ao, input logic [1:0] aa, input logic [7:0] ad,
                      input logic [1:0] bo, input logic [1:0] ba, input logic [7:0] bd,
                      input string drv_req);
    @(negedge clk);
    a_op = ao; a_addr = aa; b_op = bo; b_addr = ba;
    tb_a = ad; tb_b = bd;
    tb_a_en = (ao != 2'd2); tb_b_en = (bo != 2'd2);
    #1;
    if (ao == 2'd2) chk(drv_req, a_bus, model[aa]);
    else            chk("R7 bus A undriven", a_bus, ad);
    if (bo == 2'd2) chk(drv_req, b_bus, model[ba]);
    else            chk("R7 bus B undriven", b_bus, bd);
    @(posedge clk);
    if (ao == 2'd1) model[aa] = ad;
    if (bo == 2'd1) model[ba] = bd;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] sd;
    sd = $urandom(32'd2024);
    rst = 1; a_op = 0; b_op = 0; a_addr = 0; b_addr = 0;
    tb_a = 8'h11; tb_b = 8'h22; tb_a_en = 1; tb_b_en = 1;
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: reset contents
    for (int i = 0; i < 4; i++) step(2'd2, 2'(i), 8'h00, 2'd0, 0, 8'h5A, "R1 reset value");

    // R3 / R4: distinct values through each bus
    for (int i = 0; i < 4; i++) step(2'd1, 2'(i), 8'(8'h30 + 8'(i) * 8'h11), 2'd0, 0, 8'hC3, "R3");
    for (int i = 0; i < 4; i++) step(2'd2, 2'(i), 8'h00, 2'd2, 2'(i), 8'h00, "R3 readback both buses");
    for (int i = 0; i < 4; i++) step(2'd0, 0, 8'h3C, 2'd1, 2'(i), 8'(8'hA0 + 8'(i)), "R4");
    for (int i = 0; i < 4; i++) step(2'd2, 2'(i), 8'h00, 2'd2, 2'(3 - i), 8'h00, "R4 readback");

    // R8: load i on one bus, drive 3-i on the other
    for (int i = 0; i < 4; i++) begin
      step(2'd1, 2'(i), 8'(8'h5 + 8'(i) * 8'h40), 2'd2, 2'(3 - i), 8'h00, "R8 drive B during A load");
      step(2'd2, 2'(3 - i), 8'h00, 2'd1, 2'(i), 8'(8'hE0 ^ 8'(i)), "R8 drive A during B load");
    end
    for (int i = 0; i < 4; i++) step(2'd2, 2'(i), 8'h00, 2'd2, 2'(i), 8'h00, "R8 readback");

    // R9: same register loaded and driven in one cycle shows old value
    step(2'd1, 2'd2, 8'h77, 2'd2, 2'd2, 8'h00, "R9 old value on B");
    step(2'd2, 2'd2, 8'h00, 2'd1, 2'd2, 8'h99, "R9 new value on A, old via load B");
    step(2'd2, 2'd2, 8'h00, 2'd0, 0, 8'h66, "R9 new value visible");

    // R2 / R7: reserved code is idle; R6 untouched registers hold
    step(2'd3, 2'd1, 8'hF0, 2'd3, 2'd0, 8'h0F, "R2");
    for (int i = 0; i < 4; i++) step(2'd2, 2'(i), 8'h00, 2'd3, 2'(i), 8'h81, "R6 hold after reserved op");

    // Random traffic
    for (int k = 0; k < 600; k++) begin
      logic [1:0] ao, bo, aa, ba;
      ao = 2'($urandom); bo = 2'($urandom);
      aa = 2'($urandom); ba = 2'($urandom);
      if (ao == 2'd1 && bo == 2'd1 && aa == ba) bo = 2'd0;
      step(ao, aa, 8'($urandom), bo, ba, 8'($urandom), "R5 random drive");
    end

    // Final readback on both buses (R6)
    for (int i = 0; i < 4; i++) step(2'd2, 2'(i), 8'h00, 2'd2, 2'(3 - i), 8'h00, "R6 final readback");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule